// File: doc/BRIEF.md
# Accumulator ALU with Multiply-Accumulate

This block is the arithmetic core of a small 16-bit signal processor. It holds a 32-bit accumulator, two 16-bit operand registers X and Y, a signed product P derived from them, and two status flags, zero (Z) and negative (N). One operation is issued at a time through a valid/ready handshake. An operation is either an accumulator function (load, subtract, compare, add, AND, OR, XOR) or one of three multiply steps: accumulate, subtract, and load-clear.

Plain 16-bit operands act on the upper accumulator word and leave the lower word as it was. When the operand source is the accumulator itself or the product, the same function runs on the full 32 bits. A condition evaluator turns the flags into a single condition-true signal for the branch logic next to it. Fetching instructions and reading RAM operands happen outside; the X and Y values for a multiply step arrive on input pins.

Back-pressure: an operation is taken on a rising edge where `in_valid` and `in_ready` are both high. Long-immediate operations hold the unit for 2 cycles and double-indirect operations for 3. During the extra cycles `in_ready` is low, and the issuer must keep its request pending until `in_ready` returns.

Top module: `acc_mac_unit`

## Requirements
- R1: A synchronous reset clears the accumulator, X, Y, Z and N, and leaves `in_ready` high.
- R2: With `in_step`=0, the function codes are 0 load, 1 subtract, 4 add, 5 AND, 6 OR and 7 XOR. With a 16-bit operand, each function computes on accumulator bits 31:16 and leaves bits 15:0 unchanged.
- R3: Function code 3 (compare) sets Z and N from the subtraction result and does not write the accumulator.
- R4: In register form (`in_form`=0), a source selector of 3 (accumulator) or 7 (product) makes the function use the full 32-bit value of that source on the full accumulator.
- R5: In short-immediate form (`in_form`=1), the operand is `in_operand[7:0]` zero-extended to 16 bits.
- R6: Every accumulator operation updates Z (all 32 result bits zero) and N (result bit 31). Function codes 2 and 8 to 15 change neither the accumulator nor the flags.
- R7: A multiply-accumulate step (`in_step`=1) adds the product of the X and Y held before the step to the accumulator, and a multiply-subtract step (`in_step`=2) subtracts it. Both update Z and N and then load `in_x` and `in_y` into X and Y.
- R8: A multiply-load step (`in_step`=3) sets the accumulator to zero, sets Z, clears N, and loads `in_x` and `in_y` into X and Y.
- R9: `prod_out` always equals the signed product of X and Y shifted left by one bit, truncated to 32 bits.
- R10: `cond_true` is 1 when `cond_code`=0, equals (Z == `cond_pol`) when `cond_code`=5, equals (N == `cond_pol`) when `cond_code`=7, and is 0 for every other code.
- R11: An accumulator operation in long-immediate form (`in_form`=2) occupies 2 cycles and one in double-indirect form (`in_form`=3) occupies 3 cycles. `in_ready` stays low and the accumulator stays unchanged until the final cycle, when the result is written. Multiply steps always take 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request pending |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_func | input | 4 | Accumulator function code |
| in_step | input | 2 | 0 accumulator op, 1 multiply-add, 2 multiply-subtract, 3 multiply-load |
| in_form | input | 2 | 0 register, 1 short immediate, 2 long immediate, 3 double indirect |
| in_src | input | 4 | Source selector (3 accumulator, 7 product) |
| in_operand | input | 16 | 16-bit operand value |
| in_x | input | 16 | New X for multiply steps |
| in_y | input | 16 | New Y for multiply steps |
| cond_code | input | 4 | Condition selector |
| cond_pol | input | 1 | Flag value the condition tests for |
| acc_out | output | 32 | Accumulator |
| prod_out | output | 32 | Product register P |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| cond_true | output | 1 | Selected condition holds |

## Verification
The hardest states to reach are the ones that depend on history. A multiply step uses the X and Y latched by an earlier step, and the flags can disagree with the accumulator after a compare. The Z=1 case with a nonzero history arises only when a result lands exactly on zero. Random sequences are therefore chained without resets, so each multiply consumes operands left by earlier steps. Directed cases cover the zero results: a subtraction of the upper word from itself, an XOR of the accumulator with itself, and a multiply-load. They also cover an upper-word add whose carry must not spill into the low word, and back-to-back long and double-indirect operations whose stall cycles are probed at the handshake.

// File: rtl/acc_mac_pkg.sv
package acc_mac_pkg;
  typedef enum logic [1:0] {
    STEP_ALU     = 2'd0,
    STEP_MACADD  = 2'd1,
    STEP_MACSUB  = 2'd2,
    STEP_MACLOAD = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    FORM_REG   = 2'd0,
    FORM_SHORT = 2'd1,
    FORM_LONG  = 2'd2,
    FORM_DIND  = 2'd3
  } form_e;

  localparam logic [3:0] FN_LOAD = 4'd0;
  localparam logic [3:0] FN_SUB  = 4'd1;
  localparam logic [3:0] FN_CMP  = 4'd3;
  localparam logic [3:0] FN_ADD  = 4'd4;
  localparam logic [3:0] FN_AND  = 4'd5;
  localparam logic [3:0] FN_OR   = 4'd6;
  localparam logic [3:0] FN_XOR  = 4'd7;

  localparam logic [3:0] SRC_ACC  = 4'd3;
  localparam logic [3:0] SRC_PROD = 4'd7;

  localparam logic [3:0] CC_ALWAYS = 4'd0;
  localparam logic [3:0] CC_ZERO   = 4'd5;
  localparam logic [3:0] CC_NEG    = 4'd7;

  localparam int unsigned WAIT_W = 2;

  // Occupancy of one operation, in cycles.
  function automatic logic [WAIT_W-1:0] op_cycles(input step_e st, input form_e fm);
    if (st != STEP_ALU) return WAIT_W'(1);
    case (fm)
      FORM_LONG: return WAIT_W'(2);
      FORM_DIND: return WAIT_W'(3);
      default:   return WAIT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/amac_product.sv
module amac_product #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   x,
  input  logic [DW-1:0]   y,
  output logic [2*DW-1:0] p
);
  localparam int PW = 2 * DW;
  logic signed [PW-1:0] xs, ys, full;

  always_comb begin
    xs   = {{DW{x[DW-1]}}, x};
    ys   = {{DW{y[DW-1]}}, y};
    full = xs * ys;
    p    = full <<< 1;
  end
endmodule

// File: rtl/amac_alu.sv
module amac_alu
  import acc_mac_pkg::*;
#(
  parameter int DW = 16
) (
  input  step_e           step,
  input  form_e           form,
  input  logic [3:0]      func,
  input  logic [3:0]      src,
  input  logic [DW-1:0]   opnd,
  input  logic [2*DW-1:0] acc,
  input  logic [2*DW-1:0] prod,
  output logic [2*DW-1:0] acc_nxt,
  output logic            acc_we,
  output logic            flag_we,
  output logic            z_nxt,
  output logic            n_nxt
);
  localparam int AW = 2 * DW;

  logic          wide;
  logic [DW-1:0] v16, hi, hi_res;
  logic [AW-1:0] w_opnd, w_res, res;
  logic          known;

  always_comb begin
    wide   = (form == FORM_REG) && ((src == SRC_ACC) || (src == SRC_PROD));
    v16    = (form == FORM_SHORT) ? {{(DW-8){1'b0}}, opnd[7:0]} : opnd;
    w_opnd = (src == SRC_PROD) ? prod : acc;
    hi     = acc[AW-1:DW];

    known  = 1'b1;
    hi_res = hi;
    w_res  = acc;
    case (func)
      FN_LOAD: begin hi_res = v16;       w_res = w_opnd;       end
      FN_SUB,
      FN_CMP:  begin hi_res = hi - v16;  w_res = acc - w_opnd; end
      FN_ADD:  begin hi_res = hi + v16;  w_res = acc + w_opnd; end
      FN_AND:  begin hi_res = hi & v16;  w_res = acc & w_opnd; end
      FN_OR:   begin hi_res = hi | v16;  w_res = acc | w_opnd; end
      FN_XOR:  begin hi_res = hi ^ v16;  w_res = acc ^ w_opnd; end
      default: known = 1'b0;
    endcase

    res     = acc;
    acc_we  = 1'b0;
    flag_we = 1'b0;
    case (step)
      STEP_MACADD:  begin res = acc + prod; acc_we = 1'b1; flag_we = 1'b1; end
      STEP_MACSUB:  begin res = acc - prod; acc_we = 1'b1; flag_we = 1'b1; end
      STEP_MACLOAD: begin res = '0;         acc_we = 1'b1; flag_we = 1'b1; end
      default: begin
        res     = wide ? w_res : {hi_res, acc[DW-1:0]};
        flag_we = known;
        acc_we  = known && (func != FN_CMP);
      end
    endcase

    acc_nxt = res;
    z_nxt   = (res == '0);
    n_nxt   = res[AW-1];
  end
endmodule

// File: rtl/amac_cond.sv
module amac_cond
  import acc_mac_pkg::*;
(
  input  logic [3:0] code,
  input  logic       pol,
  input  logic       z,
  input  logic       n,
  output logic       hit
);
  always_comb begin
    case (code)
      CC_ALWAYS: hit = 1'b1;
      CC_ZERO:   hit = (z == pol);
      CC_NEG:    hit = (n == pol);
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_mac_unit.sv
module acc_mac_unit
  import acc_mac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_func,
  input  logic [1:0]      in_step,
  input  logic [1:0]      in_form,
  input  logic [3:0]      in_src,
  input  logic [DW-1:0]   in_operand,
  input  logic [DW-1:0]   in_x,
  input  logic [DW-1:0]   in_y,
  input  logic [3:0]      cond_code,
  input  logic            cond_pol,
  output logic [2*DW-1:0] acc_out,
  output logic [2*DW-1:0] prod_out,
  output logic            flag_z,
  output logic            flag_n,
  output logic            cond_true
);
  localparam int AW = 2 * DW;

  logic [AW-1:0]     acc_q;
  logic [DW-1:0]     x_q, y_q;
  logic              z_q, n_q;
  logic [WAIT_W-1:0] wait_q;

  // Operation held across a multi-cycle occupancy
  logic [3:0]    h_func, h_src;
  step_e         h_step;
  form_e         h_form;
  logic [DW-1:0] h_opnd, h_x, h_y;

  // Selected operation feeding the datapath
  logic [3:0]    s_func, s_src;
  step_e         s_step;
  form_e         s_form;
  logic [DW-1:0] s_opnd, s_x, s_y;

  logic              fire, busy, commit;
  logic [WAIT_W-1:0] n_cyc;
  logic [AW-1:0]     prod, acc_nxt;
  logic              acc_we, flag_we, z_nxt, n_nxt;

  assign busy     = (wait_q != '0);
  assign in_ready = !busy;
  assign fire     = in_valid && in_ready;
  assign n_cyc    = op_cycles(step_e'(in_step), form_e'(in_form));
  assign commit   = (fire && n_cyc == WAIT_W'(1)) || (wait_q == WAIT_W'(1));

  always_comb begin
    if (busy) begin
      s_func = h_func; s_src = h_src; s_step = h_step; s_form = h_form;
      s_opnd = h_opnd; s_x = h_x; s_y = h_y;
    end else begin
      s_func = in_func; s_src = in_src; s_step = step_e'(in_step);
      s_form = form_e'(in_form); s_opnd = in_operand; s_x = in_x; s_y = in_y;
    end
  end

  amac_product #(.DW(DW)) u_prod (.x(x_q), .y(y_q), .p(prod));

  amac_alu #(.DW(DW)) u_alu (
    .step(s_step), .form(s_form), .func(s_func), .src(s_src), .opnd(s_opnd),
    .acc(acc_q), .prod(prod), .acc_nxt(acc_nxt), .acc_we(acc_we),
    .flag_we(flag_we), .z_nxt(z_nxt), .n_nxt(n_nxt)
  );

  amac_cond u_cond (.code(cond_code), .pol(cond_pol), .z(z_q), .n(n_q), .hit(cond_true));

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0;
      h_func <= '0; h_src <= '0; h_step <= STEP_ALU; h_form <= FORM_REG;
      h_opnd <= '0; h_x <= '0; h_y <= '0;
    end else if (busy) begin
      wait_q <= wait_q - WAIT_W'(1);
    end else if (fire && n_cyc != WAIT_W'(1)) begin
      wait_q <= n_cyc - WAIT_W'(1);
      h_func <= in_func; h_src <= in_src; h_step <= step_e'(in_step);
      h_form <= form_e'(in_form); h_opnd <= in_operand; h_x <= in_x; h_y <= in_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0; x_q <= '0; y_q <= '0; z_q <= 1'b0; n_q <= 1'b0;
    end else if (commit) begin
      if (acc_we)  acc_q <= acc_nxt;
      if (flag_we) begin z_q <= z_nxt; n_q <= n_nxt; end
      if (s_step != STEP_ALU) begin x_q <= s_x; y_q <= s_y; end
    end
  end

  assign acc_out  = acc_q;
  assign prod_out = prod;
  assign flag_z   = z_q;
  assign flag_n   = n_q;
endmodule

// File: rtl/acc_mac_unit_chk.sv
module acc_mac_unit_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_func,
  input logic [1:0]      in_step,
  input logic [1:0]      in_form,
  input logic [3:0]      cond_code,
  input logic [2*DW-1:0] acc_out,
  input logic            flag_z,
  input logic            flag_n,
  input logic            cond_true
);
  logic fire;
  assign fire = in_valid && in_ready;

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> in_ready); // R1

  AST_COMPARE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (fire && in_step == 2'd0 && in_func == 4'd3 && in_form[1] == 1'b0) |=> $stable(acc_out)); // R3

  AST_MACLOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fire && in_step == 2'd3) |=> (acc_out == '0 && flag_z && !flag_n)); // R8

  AST_COND_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'd0) |-> cond_true); // R10

  AST_COND_UNUSED_FALSE: assert property (@(posedge clk) disable iff (rst)
    (cond_code != 4'd0 && cond_code != 4'd5 && cond_code != 4'd7) |-> !cond_true); // R10

  AST_LONG_STALLS: assert property (@(posedge clk) disable iff (rst)
    (fire && in_step == 2'd0 && in_form[1] == 1'b1) |=> (!in_ready && $stable(acc_out))); // R11
endmodule

bind acc_mac_unit acc_mac_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_func(in_func), .in_step(in_step), .in_form(in_form),
  .cond_code(cond_code), .acc_out(acc_out), .flag_z(flag_z),
  .flag_n(flag_n), .cond_true(cond_true)
);

// File: tb/acc_mac_unit_test.sv
module acc_mac_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [3:0] in_func = '0, in_src = '0, cond_code = '0;
  logic [1:0] in_step = '0, in_form = '0;
  logic [15:0] in_operand = '0, in_x = '0, in_y = '0;
  logic cond_pol = 1'b0;
  logic [31:0] acc_out, prod_out;
  logic flag_z, flag_n, cond_true;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_acc;
  logic [15:0] m_x, m_y;
  logic m_z, m_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_mac_unit #(.DW(DW)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] prod_f(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] t;
    t = $signed({{16{x[15]}}, x}) * $signed({{16{y[15]}}, y});
    return t <<< 1;
  endfunction

  // Reference model update, from the requirements.
  task automatic model(input logic [3:0] f, input logic [1:0] st, input logic [1:0] fm,
                       input logic [3:0] s, input logic [15:0] o,
                       input logic [15:0] x, input logic [15:0] y);
    logic [31:0] p, r, w;
    logic [15:0] v, hi;
    logic wide, wr, fl;
    p = prod_f(m_x, m_y);
    r = m_acc; wr = 1'b0; fl = 1'b0;
    if (st == 2'd1) begin r = m_acc + p; wr = 1; fl = 1; end           // R7
    else if (st == 2'd2) begin r = m_acc - p; wr = 1; fl = 1; end      // R7
    else if (st == 2'd3) begin r = 32'h0; wr = 1; fl = 1; end          // R8
    else begin
      wide = (fm == 2'd0) && (s == 4'd3 || s == 4'd7);                 // R4
      w  = (s == 4'd7) ? p : m_acc;
      v  = (fm == 2'd1) ? {8'h00, o[7:0]} : o;                         // R5
      hi = m_acc[31:16];
      fl = 1; wr = 1;
      case (f)
        4'd0: r = wide ? w : {v, m_acc[15:0]};
        4'd1, 4'd3: r = wide ? m_acc - w : {hi - v, m_acc[15:0]};
        4'd4: r = wide ? m_acc + w : {hi + v, m_acc[15:0]};
        4'd5: r = wide ? m_acc & w : {hi & v, m_acc[15:0]};
        4'd6: r = wide ? m_acc | w : {hi | v, m_acc[15:0]};
        4'd7: r = wide ? m_acc ^ w : {hi ^ v, m_acc[15:0]};
        default: begin fl = 0; wr = 0; end                             // R6
      endcase
      if (f == 4'd3) wr = 0;                                           // R3
    end
    if (fl) begin m_z = (r == 0); m_n = r[31]; end
    if (wr) m_acc = r;
    if (st != 2'd0) begin m_x = x; m_y = y; end
  endtask

  task automatic run_op(input logic [3:0] f, input logic [1:0] st, input logic [1:0] fm,
                        input logic [3:0] s, input logic [15:0] o,
                        input logic [15:0] x, input logic [15:0] y);
    int extra;
    logic [31:0] old_acc;
    extra = (st != 2'd0) ? 0 : (fm == 2'd2) ? 1 : (fm == 2'd3) ? 2 : 0;
    old_acc = m_acc;
    @(negedge clk);
    in_valid = 1; in_func = f; in_step = st; in_form = fm; in_src = s;
    in_operand = o; in_x = x; in_y = y;
    model(f, st, fm, s, o, x, y);
    @(negedge clk);
    in_valid = 0;
    for (int k = 0; k < extra; k++) begin
      check("R11 ready low while occupied", {31'b0, in_ready}, 32'h0);
      check("R11 acc held while occupied", acc_out, old_acc);
      @(negedge clk);
    end
    check("R11 ready back", {31'b0, in_ready}, 32'h1);
    check("R2 accumulator", acc_out, m_acc);
    check("R6 Z flag", {31'b0, flag_z}, {31'b0, m_z});
    check("R6 N flag", {31'b0, flag_n}, {31'b0, m_n});
    check("R9 product", prod_out, prod_f(m_x, m_y));
  endtask

  task automatic probe_cond(input logic [3:0] c, input logic pl);
    logic e;
    cond_code = c; cond_pol = pl;
    #1;
    e = (c == 4'd0) ? 1'b1 : (c == 4'd5) ? (m_z == pl) : (c == 4'd7) ? (m_n == pl) : 1'b0;
    check("R10 condition", {31'b0, cond_true}, {31'b0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    logic [3:0] fr;
    seed = $urandom(32'd7741);
    m_acc = 0; m_x = 0; m_y = 0; m_z = 0; m_n = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 acc after reset", acc_out, 32'h0);
    check("R1 ready after reset", {31'b0, in_ready}, 32'h1);
    check("R1 flags after reset", {30'b0, flag_z, flag_n}, 32'h0);
    check("R1 product after reset", prod_out, 32'h0);

    // Directed corner cases
    run_op(4'd0, 2'd0, 2'd0, 4'd0, 16'h1234, 0, 0);        // R2 load upper word
    run_op(4'd6, 2'd0, 2'd1, 4'd0, 16'hFFA5, 0, 0);        // R5 short OR uses low byte
    run_op(4'd4, 2'd0, 2'd2, 4'd0, 16'hF000, 0, 0);        // R11 long add, carry dropped
    run_op(4'd1, 2'd0, 2'd3, 4'd0, 16'h02B5, 0, 0);        // R11 double-indirect subtract
    run_op(4'd3, 2'd0, 2'd0, 4'd0, 16'h7FFF, 0, 0);        // R3 compare
    probe_cond(4'd7, 1'b1);
    run_op(4'd7, 2'd0, 2'd0, 4'd3, 16'h0000, 0, 0);        // R4 XOR with A -> zero
    probe_cond(4'd5, 1'b1);
    run_op(4'd2, 2'd0, 2'd0, 4'd0, 16'hFFFF, 0, 0);        // R6 unused code
    run_op(4'd0, 2'd3, 2'd0, 4'd0, 16'h0, 16'h8000, 16'h8000); // R8 multiply-load
    run_op(4'd0, 2'd1, 2'd0, 4'd0, 16'h0, 16'hFFFE, 16'h0003); // R7 accumulate
    run_op(4'd0, 2'd2, 2'd0, 4'd0, 16'h0, 16'h0001, 16'h0001); // R7 subtract
    run_op(4'd4, 2'd0, 2'd0, 4'd7, 16'h0, 0, 0);           // R4 add P full width
    run_op(4'd0, 2'd0, 2'd0, 4'd0, 16'h00FF, 0, 0);
    run_op(4'd1, 2'd0, 2'd1, 4'd0, 16'h00FF, 0, 0);        // R6 upper word to zero

    // Constrained random chain
    for (int i = 0; i < 600; i++) begin
      fr = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0 && fr > 4'd7) fr = fr - 4'd8;
      run_op(fr, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
             ($urandom_range(0, 2) == 0) ? 4'd7 : ($urandom_range(0, 1) == 0) ? 4'd3 : 4'($urandom),
             16'($urandom), 16'($urandom), 16'($urandom));
      probe_cond(4'($urandom_range(0, 15)), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule